// File: doc/BRIEF.md
# 24-bit Effective Address Generator

This block forms the 24-bit bus address for a 16-bit processor whose memory is split into 64 KiB banks. Each cycle it may receive an addressing-mode code with the operand bytes, the 16-bit index value, a 16-bit pointer already read for indirect modes, the data bank, the direct page base and the stack pointer. It returns the registered address one cycle later, together with a flag that marks a sequential opcode fetch.

The program bank and program counter live inside the block. An opcode fetch reads at the current bank and counter, then advances the counter. The counter wraps inside its bank and never carries into the bank. Only a far jump, which stands for a far jump, far call, far return or interrupt entry, changes the bank. A near jump reloads the counter alone.

Each mode keeps to its own bank rule. Direct page, stack-relative and vector accesses always stay in bank 0 and wrap at 64 KiB. Data-bank modes, once indexed, carry into the next bank. Long modes use a full 24-bit operand, and the long indexed mode adds the index with a carry through all 24 bits.

Top module: `ea_gen24`

## Requirements
- R1: After reset `ea` is 0, `seq_fetch` is 0, and program bank and counter are 0, so the first fetch reads address 0x000000.
- R2: The result is registered. When `req` is high, `ea` shows the address for the inputs from the previous cycle. When `req` is low, `ea` holds its value and `seq_fetch` is 0.
- R3: Mode 0 (fetch) gives `ea = {bank, pc}` and `seq_fetch = 1`, then increments pc modulo 2^16. The bank never changes, so pc 0xFFFF is followed by 0x0000 in the same bank.
- R4: `jmp_far` loads the bank and pc from `target[23:0]`. `jmp_near` loads only pc from `target[15:0]`. `jmp_far` has priority over `jmp_near`, and any jump has priority over the fetch increment.
- R5: Mode 1 gives `{dbank, opnd[15:0]}`. Mode 2 adds `idx` to that value as a 24-bit sum, so a carry raises the bank (0xFFFFFF wraps to 0).
- R6: Mode 3 gives `{0x00, (dpage + opnd[7:0]) mod 2^16}`. Mode 4 also adds `idx` inside the same modulo, so the address stays in bank 0.
- R7: Mode 5 gives `{dbank, ptr}`. Mode 6 adds `idx` to that value as a 24-bit sum with carry into the bank.
- R8: Mode 7 (stack-relative) gives `{0x00, (sp + opnd[7:0]) mod 2^16}`.
- R9: Mode 8 gives `opnd[23:0]`. Mode 9 gives `(opnd + idx) mod 2^24`.
- R10: Mode 10 (vector) gives `{0x00, opnd[15:0]}`, whatever the data or program bank holds.
- R11: Modes 11 to 15 are ignored: `ea` holds and `seq_fetch` is 0. Every mode other than 0 gives `seq_fetch = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Mode and operands are valid this cycle |
| mode | input | 4 | Addressing-mode code (see requirements) |
| opnd | input | 24 | Operand bytes, low byte first in bit order |
| idx | input | 16 | Index register value |
| ptr | input | 16 | Pointer fetched for indirect modes |
| dbank | input | 8 | Data bank register |
| dpage | input | 16 | Direct page base |
| sp | input | 16 | Stack pointer |
| jmp_near | input | 1 | Load program counter only |
| jmp_far | input | 1 | Load program bank and counter |
| target | input | 24 | Jump destination |
| ea | output | 24 | Registered effective address |
| seq_fetch | output | 1 | Address is a sequential opcode fetch |

## Verification
The hardest case to reach from the ports is the program counter wrapping inside a bank that is not zero. That needs pc at 0xFFFF, which plain fetching from reset would take 65536 cycles to reach. The stimulus uses a far jump to 0x12FFFE, then fetches three times, and expects the fetches at 0x12FFFF and 0x120000. The data modes are swept over operand, index and base values near 0xFFFF, so that every carry and wrap rule is applied.

// File: rtl/ea_gen24.sv
module ea_gen24 #(
  parameter int BW = 8,
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [3:0]       mode,
  input  logic [BW+AW-1:0] opnd,
  input  logic [AW-1:0]    idx,
  input  logic [AW-1:0]    ptr,
  input  logic [BW-1:0]    dbank,
  input  logic [AW-1:0]    dpage,
  input  logic [AW-1:0]    sp,
  input  logic             jmp_near,
  input  logic             jmp_far,
  input  logic [BW+AW-1:0] target,
  output logic [BW+AW-1:0] ea,
  output logic             seq_fetch
);
  localparam int EW = BW + AW;
  localparam logic [3:0] M_FETCH = 4'd0, M_ABS = 4'd1, M_ABSX = 4'd2, M_DIR = 4'd3,
                         M_DIRX = 4'd4, M_IND = 4'd5, M_INDX = 4'd6, M_STK = 4'd7,
                         M_LONG = 4'd8, M_LONGX = 4'd9, M_VEC = 4'd10;

  logic [AW-1:0] pc;
  logic [BW-1:0] pbank;
  logic [EW-1:0] nxt;
  logic          hit;

  wire [EW-1:0] idx_w  = {{BW{1'b0}}, idx};
  wire [AW-1:0] off8   = {{(AW-BW){1'b0}}, opnd[BW-1:0]};
  wire [AW-1:0] dp_sum = dpage + off8;
  wire [BW-1:0] zb     = '0;

  always_comb begin
    hit = 1'b1;
    nxt = ea;
    case (mode)
      M_FETCH: nxt = {pbank, pc};
      M_ABS:   nxt = {dbank, opnd[AW-1:0]};
      M_ABSX:  nxt = {dbank, opnd[AW-1:0]} + idx_w;
      M_DIR:   nxt = {zb, dp_sum};
      M_DIRX:  nxt = {zb, dp_sum + idx};
      M_IND:   nxt = {dbank, ptr};
      M_INDX:  nxt = {dbank, ptr} + idx_w;
      M_STK:   nxt = {zb, sp + off8};
      M_LONG:  nxt = opnd;
      M_LONGX: nxt = opnd + idx_w;
      M_VEC:   nxt = {zb, opnd[AW-1:0]};
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea        <= '0;
      seq_fetch <= 1'b0;
      pc        <= '0;
      pbank     <= '0;
    end else begin
      seq_fetch <= 1'b0;
      if (req && hit) begin
        ea        <= nxt;
        seq_fetch <= (mode == M_FETCH);
      end
      if (jmp_far)
        {pbank, pc} <= target;
      else if (jmp_near)
        pc <= target[AW-1:0];
      else if (req && mode == M_FETCH)
        pc <= pc + 1'b1;
    end
  end

  // R3
  seq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == M_FETCH) |=> seq_fetch);

  // R11
  no_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && mode == M_FETCH) |=> !seq_fetch);

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !jmp_far |=> $stable(pbank));

  // R6
  bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (mode == M_DIR || mode == M_DIRX || mode == M_STK || mode == M_VEC))
      |=> ea[EW-1:AW] == '0);

  // R5
  abs_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == M_ABS) |=> ea[EW-1:AW] == $past(dbank));

  // R9
  long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == M_LONG) |=> ea == $past(opnd));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || mode > M_VEC) |=> $stable(ea));
endmodule

// File: tb/ea_gen24_tb.sv
module ea_gen24_tb;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, jmp_near = 1'b0, jmp_far = 1'b0;
  logic [3:0] mode = '0;
  logic [23:0] opnd = '0, target = '0;
  logic [15:0] idx = '0, ptr = '0, dpage = '0, sp = '0;
  logic [7:0] dbank = '0;
  logic [23:0] ea;
  logic seq_fetch;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ea_gen24 u_dut (.clk, .rst_n, .req, .mode, .opnd, .idx, .ptr, .dbank, .dpage, .sp,
                  .jmp_near, .jmp_far, .target, .ea, .seq_fetch);

  task automatic chk(string r, logic [23:0] got, logic [23:0] exp, logic gs, logic es);
    nvec++;
    if (got !== exp || gs !== es) begin
      nbad++;
      $display("FAIL %s: ea=%h seq=%b expected ea=%h seq=%b", r, got, gs, exp, es);
    end
  endtask

  task automatic step(logic rq, logic [3:0] m);
    req = rq; mode = m;
    @(negedge clk);
    req = 1'b0; jmp_near = 1'b0; jmp_far = 1'b0;
  endtask

  function automatic logic [23:0] ref_ea(logic [3:0] m);
    int unsigned d = {dbank, 16'h0};
    case (m)
      4'd1: return 24'(d + opnd[15:0]);
      4'd2: return 24'(d + opnd[15:0] + idx);
      4'd3: return {8'h00, 16'(dpage + opnd[7:0])};
      4'd4: return {8'h00, 16'(dpage + opnd[7:0] + idx)};
      4'd5: return 24'(d + ptr);
      4'd6: return 24'(d + ptr + idx);
      4'd7: return {8'h00, 16'(sp + opnd[7:0])};
      4'd8: return opnd;
      4'd9: return 24'(opnd + idx);
      default: return {8'h00, opnd[15:0]};
    endcase
  endfunction

  function automatic string tag(logic [3:0] m);
    case (m)
      4'd1, 4'd2: return "R5";
      4'd3, 4'd4: return "R6";
      4'd5, 4'd6: return "R7";
      4'd7: return "R8";
      4'd8, 4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: run hung");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [23:0] e, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", ea, 24'h0, seq_fetch, 1'b0);
    step(1'b1, 4'd0); chk("R1", ea, 24'h000000, seq_fetch, 1'b1);
    step(1'b1, 4'd0); chk("R3", ea, 24'h000001, seq_fetch, 1'b1);
    // R4 far jump then R3 wrap within bank
    target = 24'h12FFFE; jmp_far = 1'b1; step(1'b0, 4'd0);
    chk("R2", ea, 24'h000001, seq_fetch, 1'b0);
    step(1'b1, 4'd0); chk("R4", ea, 24'h12FFFE, seq_fetch, 1'b1);
    step(1'b1, 4'd0); chk("R3", ea, 24'h12FFFF, seq_fetch, 1'b1);
    step(1'b1, 4'd0); chk("R3", ea, 24'h120000, seq_fetch, 1'b1);
    // R4 near jump with fetch in same cycle: jump wins
    target = 24'hAB4321; jmp_near = 1'b1; step(1'b1, 4'd0);
    chk("R4", ea, 24'h120001, seq_fetch, 1'b1);
    step(1'b1, 4'd0); chk("R4", ea, 24'h124321, seq_fetch, 1'b1);
    // R4 far beats near
    target = 24'h345678; jmp_near = 1'b1; jmp_far = 1'b1; step(1'b0, 4'd0);
    step(1'b1, 4'd0); chk("R4", ea, 24'h345678, seq_fetch, 1'b1);
    // data mode sweeps
    for (int m = 1; m <= 10; m++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 2; c++)
            for (int g = 0; g < 3; g++)
              for (int h = 0; h < 2; h++) begin
                case (a)
                  0: opnd = 24'h000000; 1: opnd = 24'h12FFF0;
                  2: opnd = 24'hFFFFFE; default: opnd = 24'h3400A7;
                endcase
                case (b)
                  0: idx = 16'h0000; 1: idx = 16'h0001;
                  2: idx = 16'h0010; default: idx = 16'hFFFF;
                endcase
                dbank = c ? 8'hFF : 8'h7F;
                dpage = (g == 0) ? 16'h0000 : (g == 1) ? 16'hFF80 : 16'hFFFF;
                sp    = h ? 16'hFFFE : 16'h01F0;
                ptr   = h ? 16'hFFF8 : 16'h0000;
                e = ref_ea(4'(m));
                step(1'b1, 4'(m));
                chk(tag(4'(m)), ea, e, seq_fetch, 1'b0);
              end
    // R2 hold with req low
    prev = ea; opnd = 24'h55AA55;
    step(1'b0, 4'd8); chk("R2", ea, prev, seq_fetch, 1'b0);
    step(1'b0, 4'd0); chk("R2", ea, prev, seq_fetch, 1'b0);
    // R11 unused codes ignored
    for (int m = 11; m <= 15; m++) begin
      step(1'b1, 4'(m)); chk("R11", ea, prev, seq_fetch, 1'b0);
    end
    // R3 bank kept across data accesses; fetch resumes at 0x345679
    step(1'b1, 4'd0); chk("R3", ea, 24'h345679, seq_fetch, 1'b1);
    // R1 reset again
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk("R1", ea, 24'h0, seq_fetch, 1'b0);
    step(1'b1, 4'd0); chk("R1", ea, 24'h000000, seq_fetch, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule